// File: doc/BRIEF.md
# Mailbox Command Responder

This block answers commands posted by a host through three 32-bit registers on a small memory-mapped port. The host places a parameter in the argument word, then writes a command identifier to the message word. That write launches execution. The response word reads zero while the command runs, then shows a completion code. Commands that hand back a value write it into the argument word before the code appears.

Execution takes a fixed, parameterised number of cycles. Internal registers hold the state that the commands manage: five clock settings in MHz, two table-address halves, a restore flag and two idle-control bits. These registers stand in for real clock generation and firmware, and they are driven out as plain outputs.

Clock requests are clamped to a configurable MHz window. Commands arriving while another is running are refused with a distinct code. Table transfers are refused until both address halves have been supplied.

Top module: `mbx_responder`

## Requirements
- R1: After reset the message, argument and response words read 0x00000000, every clock setting output equals CLK_MIN_MHZ, and the table address, restore flag and both idle outputs are 0.
- R2: A write to the message word (address 0) while idle starts the command. The response word (address 2) reads 0x00 from the next cycle for exactly EXEC_CYCLES cycles, then holds the completion code: 0x01 ok, 0xFF failed, 0xFE unknown, 0xFD prerequisite missing, 0xFC busy.
- R3: The argument word sits at address 1. A host write to the response word clears it to 0x00. Writes to address 3 are ignored, and address 3 reads zero.
- R4: Command IDs 0x4, 0x5, 0x6, 0x7 and 0x8 set clock slots 0 to 4. Each clamps its nonzero MHz argument into [CLK_MIN_MHZ, CLK_MAX_MHZ], applies the result to slot output bits [32*k+31:32*k], returns it in the argument word and completes with 0x01.
- R5: A clock-setting command whose argument is 0 completes with 0xFF. The argument word and all clock settings stay unchanged.
- R6: Command 0x2 ignores its argument, returns VERSION in the argument word and completes with 0x01.
- R7: Command 0xA returns the current setting of slot 3, the hard-minimum fabric clock, and completes with 0x01.
- R8: Any ID outside the supported set (0x2, 0x4-0x8, 0xA, 0xD, 0xE, 0xF, 0x10, 0x11, 0x12) completes with 0xFE and leaves the argument word unchanged.
- R9: A message write while a command runs, other than in its completion cycle, sets the response to 0xFC on the next cycle. It does not change the message word. The running command still completes on its original cycle with its own code and return value.
- R10: A message write in the same cycle that a command completes is discarded. The response shows the finished command's code, and no new command starts.
- R11: Commands 0x10 and 0x11 complete with 0xFD unless both 0xE (address high) and 0xF (address low) have completed since reset. After that they complete with 0x01. Commands 0xD, 0xE, 0xF, 0x10 and 0x11 leave the argument word unchanged. 0xE and 0xF load the upper and lower halves of the table address output. 0xD sets the restore flag.
- R12: Command 0x12 copies argument bit 0 to the fabric-request-off output and bit 1 to the PHY-reference-off output at completion. It leaves the argument word unchanged and completes with 0x01.
- R13: The argument is captured when the command is accepted. A host write to the argument word during execution does not change the applied value, and the completion then overwrites the argument word with the returned value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word select: 0 message, 1 argument, 2 response |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| clk_mhz | output | 160 | Five applied clock settings, 32 bits each, slot 0 lowest |
| table_addr | output | 64 | Table address, high half from 0xE, low half from 0xF |
| restore_armed | output | 1 | Set by command 0xD |
| idle_fabric_off | output | 1 | Fabric requests disabled (idle bit 0) |
| idle_phy_off | output | 1 | PHY reference clock off (idle bit 1) |

## Verification
A command's completion and a new message write can fall on the same cycle. So can an argument write by the host and the write-back of a returned value. The bench counts edges from each accepted launch and lands a second message write exactly on the completion edge. It expects the finished command's code, an unchanged message word, and no later result from the discarded ID. It also lands a message write one edge after launch and expects 0xFC at once. In that case the original code and returned value must still appear on time, and a mid-run argument write must not alter the granted clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W  = 32;
    localparam int NUM_CLK = 5;

    typedef logic [7:0] code_t;
    localparam code_t RC_PENDING = 8'h00;
    localparam code_t RC_OK      = 8'h01;
    localparam code_t RC_FAIL    = 8'hFF;
    localparam code_t RC_UNKNOWN = 8'hFE;
    localparam code_t RC_PREREQ  = 8'hFD;
    localparam code_t RC_BUSY    = 8'hFC;

    localparam logic [WORD_W-1:0] CMD_VERSION    = 32'h02;
    localparam logic [WORD_W-1:0] CMD_DISP_CLK   = 32'h04;
    localparam logic [WORD_W-1:0] CMD_REF_CLK    = 32'h05;
    localparam logic [WORD_W-1:0] CMD_PIPE_CLK   = 32'h06;
    localparam logic [WORD_W-1:0] CMD_FABRIC_MIN = 32'h07;
    localparam logic [WORD_W-1:0] CMD_SLEEP_MIN  = 32'h08;
    localparam logic [WORD_W-1:0] CMD_FABRIC_GET = 32'h0A;
    localparam logic [WORD_W-1:0] CMD_RESTORE    = 32'h0D;
    localparam logic [WORD_W-1:0] CMD_ADDR_HI    = 32'h0E;
    localparam logic [WORD_W-1:0] CMD_ADDR_LO    = 32'h0F;
    localparam logic [WORD_W-1:0] CMD_TBL_OUT    = 32'h10;
    localparam logic [WORD_W-1:0] CMD_TBL_IN     = 32'h11;
    localparam logic [WORD_W-1:0] CMD_IDLE       = 32'h12;

    // clock slot that the fabric-clock query reports
    localparam int FABRIC_SLOT = int'(CMD_FABRIC_MIN - CMD_DISP_CLK);

    localparam int IDLE_FABRIC_BIT = 0;
    localparam int IDLE_PHY_BIT    = 1;

    typedef enum logic [1:0] {
        SEL_MSG  = 2'd0,
        SEL_ARG  = 2'd1,
        SEL_RESP = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] id;
        logic [WORD_W-1:0] param;
    } cmd_t;

    typedef struct packed {
        code_t             code;
        logic              ret_en;
        logic [WORD_W-1:0] ret;
    } result_t;

    function automatic logic [WORD_W-1:0] clamp_mhz(
        input logic [WORD_W-1:0] v,
        input logic [WORD_W-1:0] lo,
        input logic [WORD_W-1:0] hi
    );
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/mbx_timer.sv
module mbx_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            cnt_q <= LOAD;
        end else if (done) begin
            busy  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        busy && cnt_q != '0 |=> busy && cnt_q == $past(cnt_q) - 1'b1);

    assert_done_ends_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/mbx_exec.sv
module mbx_exec
    import mbx_pkg::*;
#(
    parameter logic [WORD_W-1:0] CLK_MIN_MHZ = 32'd100,
    parameter logic [WORD_W-1:0] CLK_MAX_MHZ = 32'd1200,
    parameter logic [WORD_W-1:0] VERSION     = 32'h0001_0000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  cmd_t                      cmd_in,
    input  logic                      done,
    output result_t                   res,
    output logic [NUM_CLK*WORD_W-1:0] clk_mhz,
    output logic [2*WORD_W-1:0]       table_addr,
    output logic                      restore_armed,
    output logic                      idle_fabric_off,
    output logic                      idle_phy_off
);
    cmd_t              cmd_q;
    logic [WORD_W-1:0] clk_q [NUM_CLK];
    logic [WORD_W-1:0] granted;
    logic              is_clk;
    logic              hi_ok, lo_ok;
    logic              is_tbl;

    assign is_clk  = (cmd_q.id >= CMD_DISP_CLK) && (cmd_q.id < CMD_DISP_CLK + NUM_CLK);
    assign is_tbl  = (cmd_q.id == CMD_TBL_OUT) || (cmd_q.id == CMD_TBL_IN);
    assign granted = clamp_mhz(cmd_q.param, CLK_MIN_MHZ, CLK_MAX_MHZ);

    always_ff @(posedge clk) begin
        if (rst)        cmd_q <= '0;
        else if (start) cmd_q <= cmd_in;
    end

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                clk_q[g] <= CLK_MIN_MHZ;
            else if (done && cmd_q.id == CMD_DISP_CLK + g && cmd_q.param != '0)
                clk_q[g] <= granted;
        end
        assign clk_mhz[g*WORD_W +: WORD_W] = clk_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            table_addr      <= '0;
            hi_ok           <= 1'b0;
            lo_ok           <= 1'b0;
            restore_armed   <= 1'b0;
            idle_fabric_off <= 1'b0;
            idle_phy_off    <= 1'b0;
        end else if (done) begin
            case (cmd_q.id)
                CMD_ADDR_HI: begin
                    table_addr[2*WORD_W-1:WORD_W] <= cmd_q.param;
                    hi_ok <= 1'b1;
                end
                CMD_ADDR_LO: begin
                    table_addr[WORD_W-1:0] <= cmd_q.param;
                    lo_ok <= 1'b1;
                end
                CMD_RESTORE: restore_armed <= 1'b1;
                CMD_IDLE: begin
                    idle_fabric_off <= cmd_q.param[IDLE_FABRIC_BIT];
                    idle_phy_off    <= cmd_q.param[IDLE_PHY_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        res = '{code: RC_UNKNOWN, ret_en: 1'b0, ret: '0};
        case (cmd_q.id)
            CMD_VERSION: res = '{code: RC_OK, ret_en: 1'b1, ret: VERSION};
            CMD_DISP_CLK, CMD_REF_CLK, CMD_PIPE_CLK, CMD_FABRIC_MIN, CMD_SLEEP_MIN: begin
                if (cmd_q.param == '0) res = '{code: RC_FAIL, ret_en: 1'b0, ret: '0};
                else                   res = '{code: RC_OK, ret_en: 1'b1, ret: granted};
            end
            CMD_FABRIC_GET: res = '{code: RC_OK, ret_en: 1'b1, ret: clk_q[FABRIC_SLOT]};
            CMD_RESTORE, CMD_ADDR_HI, CMD_ADDR_LO, CMD_IDLE:
                res.code = RC_OK;
            CMD_TBL_OUT, CMD_TBL_IN:
                res.code = (hi_ok && lo_ok) ? RC_OK : RC_PREREQ;
            default: ;
        endcase
    end

    assert_clamp_R4: assert property (@(posedge clk) disable iff (rst)
        done && is_clk && res.code == RC_OK |->
            res.ret_en && res.ret >= CLK_MIN_MHZ && res.ret <= CLK_MAX_MHZ);

    assert_fail_keeps_clocks_R5: assert property (@(posedge clk) disable iff (rst)
        done && is_clk && cmd_q.param == '0 |=> $stable(clk_mhz));

    assert_prereq_R11: assert property (@(posedge clk) disable iff (rst)
        done && is_tbl && res.code == RC_OK |-> hi_ok && lo_ok);

endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
    import mbx_pkg::*;
#(
    parameter int                EXEC_CYCLES = 8,
    parameter logic [WORD_W-1:0] CLK_MIN_MHZ = 32'd100,
    parameter logic [WORD_W-1:0] CLK_MAX_MHZ = 32'd1200,
    parameter logic [WORD_W-1:0] VERSION     = 32'h0001_0000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_we,
    input  logic [1:0]                bus_addr,
    input  logic [WORD_W-1:0]         bus_wdata,
    output logic [WORD_W-1:0]         bus_rdata,
    output logic [NUM_CLK*WORD_W-1:0] clk_mhz,
    output logic [2*WORD_W-1:0]       table_addr,
    output logic                      restore_armed,
    output logic                      idle_fabric_off,
    output logic                      idle_phy_off
);
    reg_sel_e          sel;
    logic [WORD_W-1:0] msg_q, arg_q;
    code_t             resp_q;
    logic              msg_wr, start, busy, done;
    result_t           res;
    cmd_t              cmd_in;

    assign sel    = reg_sel_e'(bus_addr);
    assign msg_wr = bus_we && (sel == SEL_MSG);
    assign start  = msg_wr && !busy;
    assign cmd_in = '{id: bus_wdata, param: arg_q};

    mbx_timer #(.CYCLES(EXEC_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    mbx_exec #(
        .CLK_MIN_MHZ (CLK_MIN_MHZ),
        .CLK_MAX_MHZ (CLK_MAX_MHZ),
        .VERSION     (VERSION)
    ) u_exec (
        .clk             (clk),
        .rst             (rst),
        .start           (start),
        .cmd_in          (cmd_in),
        .done            (done),
        .res             (res),
        .clk_mhz         (clk_mhz),
        .table_addr      (table_addr),
        .restore_armed   (restore_armed),
        .idle_fabric_off (idle_fabric_off),
        .idle_phy_off    (idle_phy_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q  <= '0;
            arg_q  <= '0;
            resp_q <= RC_PENDING;
        end else begin
            if (bus_we && sel == SEL_ARG)  arg_q  <= bus_wdata;
            if (bus_we && sel == SEL_RESP) resp_q <= RC_PENDING;
            if (start) begin
                msg_q  <= bus_wdata;
                resp_q <= RC_PENDING;
            end else if (msg_wr && !done) begin
                resp_q <= RC_BUSY;
            end
            // completion outranks every host write in its cycle
            if (done) begin
                resp_q <= res.code;
                if (res.ret_en) arg_q <= res.ret;
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_MSG:  bus_rdata = msg_q;
            SEL_ARG:  bus_rdata = arg_q;
            SEL_RESP: bus_rdata = {{(WORD_W-8){1'b0}}, resp_q};
            default:  bus_rdata = '0;
        endcase
    end

    assert_start_pending_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> resp_q == RC_PENDING);

    assert_busy_reject_R9: assert property (@(posedge clk) disable iff (rst)
        msg_wr && busy && !done |=> resp_q == RC_BUSY && $stable(msg_q));

    assert_completion_wins_R10: assert property (@(posedge clk) disable iff (rst)
        msg_wr && done |=> !busy && resp_q == $past(res.code) && $stable(msg_q));

    assert_unknown_keeps_arg_R8: assert property (@(posedge clk) disable iff (rst)
        done && res.code == RC_UNKNOWN && !(bus_we && sel == SEL_ARG) |=> $stable(arg_q));

endmodule

// File: tb/sim_mbx_responder.sv
module sim_mbx_responder;
    localparam int          EXEC = 5;
    localparam logic [31:0] CMIN = 32'd100;
    localparam logic [31:0] CMAX = 32'd1200;
    localparam logic [31:0] VER  = 32'h0003_0105;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_we;
    logic [1:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [159:0] clk_mhz;
    logic [63:0]  table_addr;
    logic         restore_armed, idle_fabric_off, idle_phy_off;

    always #5 clk = ~clk;

    mbx_responder #(
        .EXEC_CYCLES (EXEC),
        .CLK_MIN_MHZ (CMIN),
        .CLK_MAX_MHZ (CMAX),
        .VERSION     (VER)
    ) u0 (
        .clk (clk), .rst (rst), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .clk_mhz (clk_mhz),
        .table_addr (table_addr), .restore_armed (restore_armed),
        .idle_fabric_off (idle_fabric_off), .idle_phy_off (idle_phy_off)
    );

    typedef struct {
        logic [31:0] code;
        logic [31:0] ret;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    function automatic logic [31:0] exp_clamp(input logic [31:0] v);
        if (v < CMIN) return CMIN;
        if (v > CMAX) return CMAX;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // monitor side of the scoreboard: compare the finished command
    task automatic collect();
        exp_t e;
        logic [31:0] r;
        e = sb_q.pop_front();
        rd(2'd2, r);
        check(r == e.code, {e.tag, " code"}, r, e.code);
        rd(2'd1, r);
        check(r == e.ret, {e.tag, " arg"}, r, e.ret);
    endtask

    // driver: push expectation, launch, check R2 latency, then collect
    task automatic issue(input logic [31:0] cmd, input logic [31:0] arg,
                         input logic [31:0] code, input logic [31:0] ret, input string tag);
        logic [31:0] r;
        bit early = 1'b0;
        wr(2'd1, arg);
        sb_q.push_back('{code: code, ret: ret, tag: tag});
        wr(2'd0, cmd);
        rd(2'd2, r);
        if (r != 0) early = 1'b1;
        for (int k = 1; k < EXEC; k++) begin
            @(negedge clk);
            rd(2'd2, r);
            if (r != 0) early = 1'b1;
        end
        check(!early, "R2 pending window", r, 32'h0);
        @(negedge clk);
        collect();
    endtask

    initial begin
        #(200000 * 10);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, r); check(r == 0, "R1 msg", r, 0);
        rd(2'd1, r); check(r == 0, "R1 arg", r, 0);
        rd(2'd2, r); check(r == 0, "R1 resp", r, 0);
        for (int s = 0; s < 5; s++)
            check(clk_mhz[s*32 +: 32] == CMIN, "R1 clock slot", clk_mhz[s*32 +: 32], CMIN);
        check({table_addr == 0, restore_armed, idle_fabric_off, idle_phy_off} == 4'b1000,
              "R1 state outputs", {28'h0, table_addr == 0, restore_armed, idle_fabric_off, idle_phy_off}, 32'h8);

        // R6 version ignores argument
        issue(32'h2, 32'h1234, 32'h01, VER, "R6 version");
        // R4 clamping
        issue(32'h4, 32'd600, 32'h01, exp_clamp(32'd600), "R4 in range");
        check(clk_mhz[31:0] == 32'd600, "R4 slot0 applied", clk_mhz[31:0], 32'd600);
        issue(32'h5, 32'd5000, 32'h01, exp_clamp(32'd5000), "R4 above max");
        issue(32'h8, 32'd20, 32'h01, exp_clamp(32'd20), "R4 below min");
        check(clk_mhz[4*32 +: 32] == CMIN, "R4 slot4 applied", clk_mhz[4*32 +: 32], CMIN);

        // R7 fabric query before and after setting
        issue(32'hA, 32'h0, 32'h01, CMIN, "R7 fabric default");
        issue(32'h7, 32'd700, 32'h01, 32'd700, "R7 set fabric");
        // R5 zero request fails and changes nothing
        issue(32'h7, 32'h0, 32'hFF, 32'h0, "R5 zero request");
        issue(32'hA, 32'h55, 32'h01, 32'd700, "R7 fabric after fail");

        // R8 unknown IDs
        issue(32'h3, 32'hABCD, 32'hFE, 32'hABCD, "R8 unknown 0x3");
        issue(32'h1_0004, 32'h77, 32'hFE, 32'h77, "R8 unknown wide id");

        // R3 address map
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, r); check(r == 0, "R3 response clear", r, 0);
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd3, r); check(r == 0, "R3 addr3 reads zero", r, 0);
        rd(2'd1, r); check(r == 32'h77, "R3 addr3 write ignored", r, 32'h77);

        // R11 table transfer prerequisites
        issue(32'h10, 32'h9, 32'hFD, 32'h9, "R11 out no address");
        issue(32'hE, 32'h0000_00AB, 32'h01, 32'h0000_00AB, "R11 addr high");
        issue(32'h11, 32'h8, 32'hFD, 32'h8, "R11 in with high only");
        issue(32'hF, 32'hC000_1000, 32'h01, 32'hC000_1000, "R11 addr low");
        check(table_addr == 64'h0000_00AB_C000_1000, "R11 table address", table_addr[31:0], 32'hC000_1000);
        issue(32'h10, 32'h9, 32'h01, 32'h9, "R11 out ready");
        issue(32'hD, 32'h0, 32'h01, 32'h0, "R11 restore");
        check(restore_armed == 1'b1, "R11 restore flag", {31'h0, restore_armed}, 32'h1);

        // R12 idle bits
        issue(32'h12, 32'h3, 32'h01, 32'h3, "R12 both bits");
        check({idle_fabric_off, idle_phy_off} == 2'b11, "R12 outputs 11", {30'h0, idle_fabric_off, idle_phy_off}, 32'h3);
        issue(32'h12, 32'h2, 32'h01, 32'h2, "R12 phy only");
        check({idle_fabric_off, idle_phy_off} == 2'b01, "R12 outputs 01", {30'h0, idle_fabric_off, idle_phy_off}, 32'h1);
        issue(32'h12, 32'h0, 32'h01, 32'h0, "R12 clear");

        // R9 write while busy: 0x12 with arg 403 would set both idle bits
        wr(2'd1, 32'd403);
        sb_q.push_back('{code: 32'h01, ret: 32'd403, tag: "R9 running command"});
        wr(2'd0, 32'h4);
        wr(2'd0, 32'h12);
        rd(2'd2, r); check(r == 32'hFC, "R9 busy code", r, 32'hFC);
        rd(2'd0, r); check(r == 32'h4, "R9 message kept", r, 32'h4);
        for (int k = 2; k < EXEC; k++) @(negedge clk);
        @(negedge clk);
        collect();
        check({idle_fabric_off, idle_phy_off} == 2'b00, "R9 rejected never ran", {30'h0, idle_fabric_off, idle_phy_off}, 32'h0);

        // R10 message write on the completion edge
        wr(2'd1, 32'd250);
        sb_q.push_back('{code: 32'h01, ret: 32'd250, tag: "R10 finished command"});
        wr(2'd0, 32'h6);
        for (int k = 1; k < EXEC; k++) @(negedge clk);
        wr(2'd0, 32'h33);
        collect();
        rd(2'd0, r); check(r == 32'h6, "R10 message kept", r, 32'h6);
        repeat (EXEC + 2) @(negedge clk);
        rd(2'd2, r); check(r == 32'h01, "R10 no new command", r, 32'h01);

        // R13 argument captured at launch
        wr(2'd1, 32'd300);
        sb_q.push_back('{code: 32'h01, ret: 32'd300, tag: "R13 captured argument"});
        wr(2'd0, 32'h4);
        wr(2'd1, 32'd900);
        for (int k = 2; k < EXEC; k++) @(negedge clk);
        @(negedge clk);
        collect();
        check(clk_mhz[31:0] == 32'd300, "R13 applied value", clk_mhz[31:0], 32'd300);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule